// File: doc/BRIEF.md
# Staircase sliding-window hard-decision decoder

This block corrects bit errors in a stream of 8x8 binary blocks protected by a staircase construction. Each bit belongs to two component words of a 16-bit extended Hamming code, which can correct one error. Every component word is formed from the eight bits of one column of an older block followed by the eight bits of one row of the block that came after it. The decoder holds three consecutive blocks. It keeps one 5-bit syndrome register for each component word that lies in that window. It then works through the words one at a time and applies single-error correction.

Rows arrive one per cycle while the block is idle. When the eighth row of a block is accepted, the window moves forward by one block. All syndromes are then recomputed, and decoding runs as alternating passes. The first pass covers the words that join the oldest and middle blocks. The second pass covers the words that join the middle and newest blocks. Each flip in the middle block is applied at once to the syndrome of the word that crosses it. Decoding stops after a full iteration in which nothing flipped, or after the iteration cap. The oldest block is then streamed out one row per cycle, and the block returns to idle. Each block therefore leaves the decoder two blocks after it arrived. Before any data arrives, the window holds all-zero blocks.

Top module: `staircase_window_dec`

## Requirements
- R1: While reset is asserted and immediately after it is released, `busy`, `out_valid` and `done` are 0, and all three window blocks hold zeros.
- R2: In idle, each cycle with `in_valid` high stores `in_row` as the next row of an incoming block, starting at row 0. Bit j of a row is column j. On the eighth row the window shifts: oldest takes middle, middle takes newest, newest takes the incoming block. `busy` then rises on the next cycle.
- R3: Rows offered while `busy` is high are ignored. They do not change the stored rows or the row count of the next block.
- R4: A component word is valid when the XOR of the 4-bit indices of its set bits is zero and its weight is even. Within a word, new-row bit j has index j for j<7 and index 8 for j=7. Old-column bit j has index 7 for j=0 and index 8+j otherwise. A word with odd overall parity has the bit at the syndrome's index flipped, and its own syndrome is cleared.
- R5: A word whose syndrome is nonzero with even overall parity is a failure. No bit is changed.
- R6: A flip in the middle block takes effect immediately in the syndrome of the crossing word of the other family. A later word can therefore become correctable within the same window.
- R7: Each iteration takes 16 cycles: the 8 oldest/middle words by middle-block row index, then the 8 middle/newest words by middle-block column index. Decoding ends after the first iteration with no flip. For n iterations, the first output row appears 1+16n cycles after the clock edge that accepted the eighth input row.
- R8: Decoding stops after MAX_ITER (default 4) iterations even if the last iteration flipped bits.
- R9: The output is the oldest block, rows 0 to 7, on 8 consecutive cycles with `out_valid` high. `done` is high only with row 7, and the next cycle is idle.
- R10: The block emitted after block k is accepted is the corrected block k-2. The first two emissions are all-zero blocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Incoming row present |
| in_row | input | 8 | Incoming hard-decision row |
| busy | output | 1 | Decoding or emitting; input ignored |
| out_valid | output | 1 | Decoded row present |
| out_row | output | 8 | Decoded row of the oldest block |
| done | output | 1 | Marks the last row of an emitted block |

## Verification
A syndrome register that misses a crossing update, or is not cleared, shows up in two ways. The iteration count changes, and this can be seen in the output latency of the same window. A wrong bit also appears in the emitted block two windows later. A staging count disturbed by ignored input shifts every later block, so the next emitted rows stop matching. The error patterns include a chain in which each correction makes the next one possible. This chain makes the crossing-syndrome path and the iteration cap show directly in latency.

// File: rtl/staircase_window_dec.sv
module staircase_window_dec #(
  parameter int MAX_ITER = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_row,
  output logic       busy,
  output logic       out_valid,
  output logic [7:0] out_row,
  output logic       done
);
  localparam int IW  = (MAX_ITER > 1) ? $clog2(MAX_ITER) : 1;
  localparam int DCW = $clog2(16 * MAX_ITER + 1);

  typedef enum logic [1:0] {S_IDLE, S_SYN, S_DEC, S_OUT} st_t;

  st_t              st;
  logic [2:0]       cnt, ptr;
  logic [63:0]      stg, b0, b1, b2;
  logic [7:0][4:0]  synh, synv, hinit, vinit;
  logic             fam, moved;
  logic [IW-1:0]    iter;

  function automatic logic [3:0] nidx(input logic [2:0] j);
    return (j == 3'd7) ? 4'd8 : {1'b0, j};
  endfunction

  function automatic logic [3:0] oidx(input logic [2:0] j);
    return (j == 3'd0) ? 4'd7 : {1'b1, j};
  endfunction

  function automatic logic [4:0] wsyn(input logic [7:0] ob, input logic [7:0] nb);
    logic [4:0] s;
    s = '0;
    for (int j = 0; j < 8; j++) begin
      if (nb[j]) s = s ^ {1'b1, nidx(3'(j))};
      if (ob[j]) s = s ^ {1'b1, oidx(3'(j))};
    end
    return s;
  endfunction

  function automatic logic [7:0] colof(input logic [63:0] x, input logic [2:0] k);
    logic [7:0] c;
    for (int r = 0; r < 8; r++) c[r] = x[r*8 + int'(k)];
    return c;
  endfunction

  always_comb begin
    for (int k = 0; k < 8; k++) begin
      hinit[k] = wsyn(colof(b0, 3'(k)), b1[k*8 +: 8]);
      vinit[k] = wsyn(colof(b1, 3'(k)), b2[k*8 +: 8]);
    end
  end

  logic [4:0] cur_syn;
  logic [3:0] pos;
  logic [2:0] pj;
  logic       fix, in_new, last, stop;

  assign cur_syn = fam ? synv[ptr] : synh[ptr];
  assign pos     = cur_syn[3:0];
  assign fix     = (st == S_DEC) && cur_syn[4];
  assign in_new  = (pos == 4'd8) || (pos < 4'd7);
  assign pj      = (pos == 4'd8) ? 3'd7 : (pos == 4'd7) ? 3'd0 : pos[2:0];
  assign last    = fam && (ptr == 3'd7);
  assign stop    = last && (!(moved || fix) || iter == IW'(MAX_ITER - 1));

  assign busy      = (st != S_IDLE);
  assign out_valid = (st == S_OUT);
  assign out_row   = b0[{cnt, 3'b000} +: 8];
  assign done      = (st == S_OUT) && (cnt == 3'd7);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; ptr <= '0; fam <= 1'b0; moved <= 1'b0; iter <= '0;
      stg <= '0; b0 <= '0; b1 <= '0; b2 <= '0; synh <= '0; synv <= '0;
    end else begin
      case (st)
        S_IDLE: if (in_valid) begin
          stg[{cnt, 3'b000} +: 8] <= in_row;
          if (cnt == 3'd7) begin
            b0 <= b1; b1 <= b2; b2 <= {in_row, stg[55:0]};
            cnt <= '0; st <= S_SYN;
          end else cnt <= cnt + 3'd1;
        end
        S_SYN: begin
          synh <= hinit; synv <= vinit;
          fam <= 1'b0; ptr <= '0; iter <= '0; moved <= 1'b0;
          st <= S_DEC;
        end
        S_DEC: begin
          if (fix) begin
            moved <= 1'b1;
            if (!fam) begin
              synh[ptr] <= '0;
              if (in_new) begin
                b1[{ptr, pj}] <= ~b1[{ptr, pj}];
                synv[pj] <= synv[pj] ^ {1'b1, oidx(ptr)};
              end else b0[{pj, ptr}] <= ~b0[{pj, ptr}];
            end else begin
              synv[ptr] <= '0;
              if (in_new) b2[{ptr, pj}] <= ~b2[{ptr, pj}];
              else begin
                b1[{pj, ptr}] <= ~b1[{pj, ptr}];
                synh[pj] <= synh[pj] ^ {1'b1, nidx(ptr)};
              end
            end
          end
          if (last) begin
            if (stop) begin
              st <= S_OUT; cnt <= '0;
            end else begin
              iter <= iter + 1'b1; moved <= 1'b0; fam <= 1'b0; ptr <= '0;
            end
          end else begin
            ptr <= ptr + 3'd1;
            if (ptr == 3'd7) fam <= 1'b1;
          end
        end
        S_OUT: begin
          if (cnt == 3'd7) begin
            st <= S_IDLE; cnt <= '0;
          end else cnt <= cnt + 3'd1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [DCW-1:0] dec_cycles;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dec_cycles <= '0;
    else if (st == S_SYN) dec_cycles <= '0;
    else if (st == S_DEC) dec_cycles <= dec_cycles + 1'b1;
  end

  // R8
  dec_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DEC) |-> (dec_cycles < DCW'(16 * MAX_ITER)));

  // R5
  fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DEC && cur_syn != 5'd0 && !cur_syn[4]) |=> ($stable(b0) && $stable(b1) && $stable(b2)));

  // R4
  syn_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DEC && !fam && cur_syn[4]) |=> (synh[$past(ptr)] == 5'd0));

  // R2
  shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && in_valid && cnt == 3'd7) |=> (b0 == $past(b1) && b1 == $past(b2) && busy));

  // R7
  stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DEC && last && !moved && !cur_syn[4]) |=> out_valid);

  // R9
  done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!busy && !out_valid));
endmodule

// File: tb/sim_staircase_window_dec.sv
module sim_staircase_window_dec;
  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [7:0] in_row = '0;
  logic busy, out_valid, done;
  logic [7:0] out_row;
  int checks = 0, fails = 0;

  staircase_window_dec u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_row(in_row),
                           .busy(busy), .out_valid(out_valid), .out_row(out_row), .done(done));

  always #2 clk = ~clk;

  // info[47:24], errA[23:16], errB[15:8], iterations[7:4], poke[0]; err: [7] en, [5:3] row, [2:0] col
  localparam logic [47:0] TBL [6] = '{
    {24'h5A3C96, 8'h00, 8'h00, 4'd1, 4'd0},
    {24'h1F2E4D, 8'h95, 8'h00, 4'd2, 4'd0},
    {24'hC3A517, 8'hA1, 8'hA6, 4'd1, 4'd0},
    {24'h7E0192, 8'h00, 8'h00, 4'd2, 4'd1},
    {24'h2B6DF0, 8'h80, 8'hBF, 4'd2, 4'd0},
    {24'h94C3E8, 8'h00, 8'h00, 4'd1, 4'd0}
  };

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] ni(input int j);
    return (j == 7) ? 4'd8 : 4'(j);
  endfunction

  function automatic logic [3:0] oi(input int j);
    return (j == 0) ? 4'd7 : 4'(8 + j);
  endfunction

  function automatic logic [63:0] encode(input logic [63:0] prev, input logic [23:0] info);
    logic [63:0] nb;
    nb = '0;
    for (int r = 0; r < 8; r++) begin
      logic [3:0] s;
      logic p;
      logic [7:0] row;
      s = '0; p = 1'b0; row = '0;
      row[3] = info[3*r]; row[5] = info[3*r+1]; row[6] = info[3*r+2];
      for (int j = 0; j < 8; j++) begin
        if (prev[j*8 + r]) begin s = s ^ oi(j); p = ~p; end
        if (row[j]) begin s = s ^ ni(j); p = ~p; end
      end
      row[1] = s[0]; row[2] = s[1]; row[4] = s[2]; row[7] = s[3];
      row[0] = p ^ s[0] ^ s[1] ^ s[2] ^ s[3];
      nb[r*8 +: 8] = row;
    end
    return nb;
  endfunction

  task automatic run_window(input logic [63:0] sent, input int n_iter, input logic [63:0] exp_out,
                            input bit poke, input string lat_tag, input string dat_tag);
    int lat;
    for (int r = 0; r < 8; r++) begin
      @(negedge clk); in_valid = 1'b1; in_row = sent[r*8 +: 8];
    end
    @(negedge clk); in_valid = 1'b0; lat = 1;
    chk(busy == 1'b1, "R2 busy after eighth row", 64'(busy), 64'd1);
    while (!out_valid && lat < 300) begin
      @(negedge clk); lat++;
      in_valid = poke && (lat == 5) && !out_valid;
      in_row = 8'hFF;
    end
    in_valid = 1'b0;
    chk(lat == 2 + 16 * n_iter, {lat_tag, " first-row latency"}, 64'(lat), 64'(2 + 16 * n_iter));
    for (int r = 0; r < 8; r++) begin
      if (r > 0) @(negedge clk);
      chk(out_valid == 1'b1, "R9 out_valid run", 64'(out_valid), 64'd1);
      chk(out_row == exp_out[r*8 +: 8], {dat_tag, " emitted row"}, 64'(out_row), 64'(exp_out[r*8 +: 8]));
      chk(done == (r == 7), "R9 done position", 64'(done), 64'(r == 7));
    end
    @(negedge clk);
    chk(!busy && !out_valid, "R9 idle after block", {62'd0, busy, out_valid}, 64'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] h1, h2, clean, sent;
    logic [47:0] e;
    bit prev_poke;
    h1 = '0; h2 = '0; prev_poke = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && !out_valid && !done, "R1 reset outputs", {61'd0, busy, out_valid, done}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !out_valid && !done, "R1 after release", {61'd0, busy, out_valid, done}, 64'd0);

    for (int i = 0; i < 6; i++) begin
      e = TBL[i];
      clean = encode(h1, e[47:24]);
      sent = clean;
      if (e[23]) sent[e[21:16]] = ~sent[e[21:16]];
      if (e[15]) sent[e[13:8]]  = ~sent[e[13:8]];
      run_window(sent, int'(e[7:4]), h2, e[0],
                 (e[7:4] == 4'd1) ? "R5 R7" : "R4 R7",
                 prev_poke ? "R3 R10" : "R4 R10");
      prev_poke = e[0];
      h2 = h1; h1 = clean;
    end

    // R6 chain: errors that resolve one word after another across iterations
    clean = encode(h1, 24'h3D5A61);
    sent = clean;
    sent[6'o00] = ~sent[6'o00]; sent[6'o01] = ~sent[6'o01];
    sent[6'o11] = ~sent[6'o11]; sent[6'o12] = ~sent[6'o12];
    sent[6'o22] = ~sent[6'o22]; sent[6'o23] = ~sent[6'o23];
    sent[6'o33] = ~sent[6'o33]; sent[6'o34] = ~sent[6'o34];
    run_window(sent, 1, h2, 1'b0, "R5 R7", "R10");
    h2 = h1; h1 = clean;

    clean = encode(h1, 24'hA0F7C4);
    sent = clean;
    sent[6'o46] = ~sent[6'o46];
    run_window(sent, 4, h2, 1'b0, "R6 R8", "R10");
    h2 = h1; h1 = clean;

    clean = encode(h1, 24'h6B18D3);
    run_window(clean, 3, h2, 1'b0, "R6 R7", "R6 R4");
    h2 = h1; h1 = clean;

    clean = encode(h1, 24'h0E9B27);
    run_window(clean, 1, h2, 1'b0, "R7", "R6 R10");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule